// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block keeps three 256-bit sets of per-vector state: requests waiting for service, vectors currently being serviced by the core, and the trigger kind (edge or level) of each vector. From a task-priority register and the highest vector in service it derives a processor priority. It then offers the core the highest waiting vector whose priority class beats that value. The priority class of a vector is its upper nibble.

The core acknowledges the offered vector, which moves it from waiting to in service. Software retires work with an end-of-interrupt strobe. That strobe clears the highest in-service vector, and one cycle later the block reports which vector was retired and whether it was level-triggered, so that a level source can re-arm. Requests arrive on an accept port. The accept port only takes requests while both a hardware enable and a software enable are high, and one cycle later it reports whether the request set a bit that was previously clear.

Top module: `vic_top`

## Requirements
- R1: After reset no vector is waiting or in service, `procPri` is 0, and `dlvValid`, `reqNew` and `eoiOutValid` are low.
- R2: `dlvVec` is the highest-numbered waiting vector, searched across all eight 32-bit words. It reflects a state change in the cycle right after the edge that caused it.
- R3: `procPri` equals the task priority when the task priority's bits [7:4] are greater than or equal to bits [7:4] of the highest in-service vector. Otherwise it equals that vector with bits [3:0] forced to zero. An empty in-service set counts as vector 0.
- R4: `dlvValid` is high only if the highest waiting vector, with bits [3:0] zeroed, is strictly greater than `procPri`. With nothing waiting, `dlvValid` is low.
- R5: `ackStrobe` while `dlvValid` is high marks the offered vector in service and removes it from the waiting set. With `dlvValid` low, `ackStrobe` has no effect.
- R6: `eoiStrobe` clears the highest in-service vector. In the next cycle `eoiOutValid` pulses for one cycle with that vector on `eoiOutVec`. With nothing in service, `eoiStrobe` changes nothing and no pulse appears.
- R7: An accepted request records its trigger kind: level when `reqLevel` is 1, edge when it is 0. `eoiOutLevel` reports the recorded kind of the retired vector and then clears it.
- R8: A level request for a vector that is already waiting is dropped and leaves that vector's recorded trigger kind unchanged.
- R9: A task-priority write replaces the 8-bit task priority, and `procPri` reflects it in the next cycle.
- R10: Requests are ignored unless `hwEnable` and `swEnable` are both high.
- R11: `reqNew` is high for exactly the cycle after an accepted request whose waiting bit was clear beforehand.
- R12: When several strobes fall in one cycle they are applied in this order: acknowledge, then end-of-interrupt, then accept. A request for the vector being acknowledged in that cycle therefore counts as new.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hwEnable | input | 1 | Hardware enable for requests |
| swEnable | input | 1 | Software enable for requests |
| reqValid | input | 1 | Request strobe |
| reqVec | input | 8 | Requested vector |
| reqLevel | input | 1 | 1 = level request, 0 = edge request |
| reqNew | output | 1 | Previous-cycle request set a clear waiting bit |
| tprWrValid | input | 1 | Task-priority write strobe |
| tprWrData | input | 8 | New task priority |
| ackStrobe | input | 1 | Core takes the offered vector |
| eoiStrobe | input | 1 | End-of-interrupt |
| dlvValid | output | 1 | A vector is deliverable |
| dlvVec | output | 8 | Highest waiting vector |
| procPri | output | 8 | Processor priority |
| eoiOutValid | output | 1 | Retirement notification |
| eoiOutVec | output | 8 | Retired vector |
| eoiOutLevel | output | 1 | Retired vector was level-triggered |

## Verification
Acknowledge, end-of-interrupt and a new request can all land in the same cycle. The sharpest case is a request for the very vector being acknowledged, combined with a retirement whose trigger bit the request may rewrite. The bench drives these collisions on purpose and also produces them at random. A behavioural model applies the same acknowledge, retire, accept order to plain bit arrays, and its results are compared with the outputs every cycle, including the trigger kind reported on the following retirement.

// File: rtl/vic_pkg.sv
`timescale 1ns/1ps
package vic_pkg;
  typedef struct packed {
    logic ack;       // move offered vector to in-service
    logic eoi;       // retire highest in-service vector
    logic accept;    // set waiting bit of reqVec
    logic tmrWrite;  // update trigger kind of reqVec
    logic newFlag;   // waiting bit was clear before this request
  } ctrlStrobes_t;
endpackage

// File: rtl/vic_find_top.sv
`timescale 1ns/1ps
module vic_find_top #(
  parameter int NUM_VEC = 256,
  parameter int WORD_W  = 32
) (
  input  logic [NUM_VEC-1:0]         vec,
  output logic                       valid,
  output logic [$clog2(NUM_VEC)-1:0] idx
);
  localparam int VEC_W     = $clog2(NUM_VEC);
  localparam int NUM_WORDS = NUM_VEC / WORD_W;
  localparam int BIT_W     = $clog2(WORD_W);

  logic [NUM_WORDS-1:0] wordAny;
  logic [BIT_W-1:0]     wordTop [NUM_WORDS];

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    always_comb begin
      wordTop[w] = '0;
      for (int b = 0; b < WORD_W; b++)
        if (vec[w*WORD_W + b]) wordTop[w] = BIT_W'(b);
    end
    assign wordAny[w] = |vec[w*WORD_W +: WORD_W];
  end

  // upper words overwrite lower ones: highest set word wins
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    for (int w = 0; w < NUM_WORDS; w++)
      if (wordAny[w]) begin
        valid = 1'b1;
        idx   = VEC_W'(w * WORD_W) | VEC_W'(wordTop[w]);
      end
  end
endmodule

// File: rtl/vic_ctrl.sv
`timescale 1ns/1ps
module vic_ctrl
  import vic_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             hwEnable,
  input  logic             swEnable,
  input  logic             reqValid,
  input  logic             reqLevel,
  input  logic [VEC_W-1:0] reqVec,
  input  logic             ackStrobe,
  input  logic             eoiStrobe,
  input  logic             dlvValid,
  input  logic [VEC_W-1:0] dlvVec,
  input  logic             isrValid,
  input  logic             pendHit,
  output ctrlStrobes_t     strb
);
  logic ackHitsReq, prevSet, accepted;

  always_comb begin
    strb.ack    = ackStrobe && dlvValid;
    strb.eoi    = eoiStrobe && isrValid;
    accepted    = reqValid && hwEnable && swEnable;
    // acknowledge is applied first, so it empties the bit a request may hit
    ackHitsReq  = strb.ack && (dlvVec == reqVec);
    prevSet     = pendHit && !ackHitsReq;
    strb.accept   = accepted;
    strb.tmrWrite = accepted && !(prevSet && reqLevel);
    strb.newFlag  = accepted && !prevSet;
  end
endmodule

// File: rtl/vic_datapath.sv
`timescale 1ns/1ps
module vic_datapath
  import vic_pkg::*;
#(
  parameter int NUM_VEC = 256,
  parameter int WORD_W  = 32,
  parameter int CLS_LSB = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobes_t               strb,
  input  logic [$clog2(NUM_VEC)-1:0] reqVec,
  input  logic                       reqLevel,
  input  logic                       tprWrValid,
  input  logic [$clog2(NUM_VEC)-1:0] tprWrData,
  output logic                       dlvValid,
  output logic [$clog2(NUM_VEC)-1:0] dlvVec,
  output logic [$clog2(NUM_VEC)-1:0] procPri,
  output logic                       isrValid,
  output logic                       pendHit,
  output logic                       reqNew,
  output logic                       eoiOutValid,
  output logic [$clog2(NUM_VEC)-1:0] eoiOutVec,
  output logic                       eoiOutLevel
);
  localparam int VEC_W = $clog2(NUM_VEC);
  localparam logic [VEC_W-1:0] CLS_MASK = ~VEC_W'((1 << CLS_LSB) - 1);

  logic [NUM_VEC-1:0] irr, isr, tmr;
  logic [NUM_VEC-1:0] irrNext, isrNext, tmrNext;
  logic [NUM_VEC-1:0] ackMask, eoiMask;
  logic [VEC_W-1:0]   tpr, irrTop, isrTop, isrPri;
  logic               irrValid;

  vic_find_top #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) irrFind_i (
    .vec(irr), .valid(irrValid), .idx(irrTop));
  vic_find_top #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) isrFind_i (
    .vec(isr), .valid(isrValid), .idx(isrTop));

  always_comb begin
    isrPri   = isrValid ? (isrTop & CLS_MASK) : '0;
    procPri  = ((tpr & CLS_MASK) >= isrPri) ? tpr : isrPri;
    dlvVec   = irrTop;
    dlvValid = irrValid && ((irrTop & CLS_MASK) > procPri);
    pendHit  = irr[reqVec];
  end

  always_comb begin
    ackMask = strb.ack ? (NUM_VEC'(1) << irrTop) : '0;
    eoiMask = strb.eoi ? (NUM_VEC'(1) << isrTop) : '0;
    irrNext = irr & ~ackMask;
    if (strb.accept) irrNext[reqVec] = 1'b1;
    isrNext = (isr | ackMask) & ~eoiMask;
    tmrNext = tmr & ~eoiMask;
    if (strb.tmrWrite) tmrNext[reqVec] = reqLevel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irr         <= '0;
      isr         <= '0;
      tmr         <= '0;
      tpr         <= '0;
      reqNew      <= 1'b0;
      eoiOutValid <= 1'b0;
      eoiOutVec   <= '0;
      eoiOutLevel <= 1'b0;
    end else begin
      irr         <= irrNext;
      isr         <= isrNext;
      tmr         <= tmrNext;
      if (tprWrValid) tpr <= tprWrData;
      reqNew      <= strb.newFlag;
      eoiOutValid <= strb.eoi;
      if (strb.eoi) begin
        eoiOutVec   <= isrTop;
        eoiOutLevel <= tmr[isrTop];
      end
    end
  end
endmodule

// File: rtl/vic_top.sv
`timescale 1ns/1ps
module vic_top
  import vic_pkg::*;
#(
  parameter int NUM_VEC = 256,
  parameter int WORD_W  = 32,
  parameter int CLS_LSB = 4,
  localparam int VEC_W  = $clog2(NUM_VEC)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hwEnable,
  input  logic             swEnable,
  input  logic             reqValid,
  input  logic [VEC_W-1:0] reqVec,
  input  logic             reqLevel,
  output logic             reqNew,
  input  logic             tprWrValid,
  input  logic [VEC_W-1:0] tprWrData,
  input  logic             ackStrobe,
  input  logic             eoiStrobe,
  output logic             dlvValid,
  output logic [VEC_W-1:0] dlvVec,
  output logic [VEC_W-1:0] procPri,
  output logic             eoiOutValid,
  output logic [VEC_W-1:0] eoiOutVec,
  output logic             eoiOutLevel
);
  ctrlStrobes_t strb;
  logic isrValid, pendHit;

  vic_ctrl #(.VEC_W(VEC_W)) ctrl_i (
    .hwEnable(hwEnable), .swEnable(swEnable), .reqValid(reqValid),
    .reqLevel(reqLevel), .reqVec(reqVec), .ackStrobe(ackStrobe),
    .eoiStrobe(eoiStrobe), .dlvValid(dlvValid), .dlvVec(dlvVec),
    .isrValid(isrValid), .pendHit(pendHit), .strb(strb));

  vic_datapath #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W), .CLS_LSB(CLS_LSB)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .reqVec(reqVec), .reqLevel(reqLevel),
    .tprWrValid(tprWrValid), .tprWrData(tprWrData), .dlvValid(dlvValid),
    .dlvVec(dlvVec), .procPri(procPri), .isrValid(isrValid), .pendHit(pendHit),
    .reqNew(reqNew), .eoiOutValid(eoiOutValid), .eoiOutVec(eoiOutVec),
    .eoiOutLevel(eoiOutLevel));
endmodule

// File: rtl/vic_checker.sv
`timescale 1ns/1ps
module vic_checker #(
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             hwEnable,
  input logic             swEnable,
  input logic             reqValid,
  input logic             reqNew,
  input logic             tprWrValid,
  input logic [VEC_W-1:0] tprWrData,
  input logic             ackStrobe,
  input logic             eoiStrobe,
  input logic             dlvValid,
  input logic [VEC_W-1:0] dlvVec,
  input logic [VEC_W-1:0] procPri,
  input logic             eoiOutValid
);
  // R5
  ack_retires_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackStrobe && dlvValid) |=> !(dlvValid && dlvVec == $past(dlvVec)));

  // R9
  tpr_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    tprWrValid |=> (procPri >= $past(tprWrData)));

  // R6
  eoi_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    eoiOutValid |-> $past(eoiStrobe));

  // R11
  new_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqNew |-> $past(reqValid && hwEnable && swEnable));

  // R10
  gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !(hwEnable && swEnable)) |=> !reqNew);
endmodule

bind vic_top vic_checker chk_i (
  .clk(clk), .rstN(rstN), .hwEnable(hwEnable), .swEnable(swEnable),
  .reqValid(reqValid), .reqNew(reqNew), .tprWrValid(tprWrValid),
  .tprWrData(tprWrData), .ackStrobe(ackStrobe), .eoiStrobe(eoiStrobe),
  .dlvValid(dlvValid), .dlvVec(dlvVec), .procPri(procPri),
  .eoiOutValid(eoiOutValid));

// File: tb/vic_top_tb.sv
`timescale 1ns/1ps
module vic_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hwEnable = 1'b0, swEnable = 1'b0;
  logic reqValid = 1'b0, reqLevel = 1'b0;
  logic [7:0] reqVec = '0;
  logic tprWrValid = 1'b0;
  logic [7:0] tprWrData = '0;
  logic ackStrobe = 1'b0, eoiStrobe = 1'b0;
  logic reqNew, dlvValid, eoiOutValid, eoiOutLevel;
  logic [7:0] dlvVec, procPri, eoiOutVec;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  // reference state
  logic [255:0] mIrr = '0, mIsr = '0, mTmr = '0;
  int mTpr = 0;
  bit mNew = 0, mEoiV = 0, mEoiLvl = 0;
  int mEoiVec = 0;

  always #2.5 clk = ~clk;

  vic_top dut_i (
    .clk(clk), .rstN(rstN), .hwEnable(hwEnable), .swEnable(swEnable),
    .reqValid(reqValid), .reqVec(reqVec), .reqLevel(reqLevel), .reqNew(reqNew),
    .tprWrValid(tprWrValid), .tprWrData(tprWrData), .ackStrobe(ackStrobe),
    .eoiStrobe(eoiStrobe), .dlvValid(dlvValid), .dlvVec(dlvVec),
    .procPri(procPri), .eoiOutValid(eoiOutValid), .eoiOutVec(eoiOutVec),
    .eoiOutLevel(eoiOutLevel));

  function automatic int mHighest(logic [255:0] a);
    for (int i = 255; i >= 0; i--) if (a[i]) return i;
    return -1;
  endfunction

  function automatic int mPpr();
    int it = mHighest(mIsr);
    int iv = (it < 0) ? 0 : it;
    return ((mTpr & 'hF0) >= (iv & 'hF0)) ? mTpr : (iv & 'hF0);
  endfunction

  function automatic int mDeliver();
    int h = mHighest(mIrr);
    if (h < 0) return -1;
    return ((h & 'hF0) > mPpr()) ? h : -1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic modelUpdate();
    int dl = mDeliver();
    int it = mHighest(mIsr);
    bit prev;
    if (ackStrobe && dl >= 0) begin mIsr[dl] = 1'b1; mIrr[dl] = 1'b0; end
    mEoiV = eoiStrobe && it >= 0;
    if (mEoiV) begin
      mEoiVec = it; mEoiLvl = mTmr[it]; mIsr[it] = 1'b0; mTmr[it] = 1'b0;
    end
    mNew = 0;
    if (reqValid && hwEnable && swEnable) begin
      prev = mIrr[reqVec];
      if (!(prev && reqLevel)) mTmr[reqVec] = reqLevel;
      mIrr[reqVec] = 1'b1;
      mNew = !prev;
    end
    if (tprWrValid) mTpr = tprWrData;
  endtask

  task automatic compareAll();
    int dl = mDeliver();
    chk(dlvValid == (dl >= 0), "R4 dlvValid", dlvValid, dl >= 0);
    if (dl >= 0) chk(dlvVec == dl[7:0], "R2 dlvVec", dlvVec, dl);
    chk(procPri == mPpr(), "R3 procPri", procPri, mPpr());
    chk(reqNew == mNew, "R11 reqNew", reqNew, mNew);
    chk(eoiOutValid == mEoiV, "R6 eoiOutValid", eoiOutValid, mEoiV);
    if (mEoiV) begin
      chk(eoiOutVec == mEoiVec[7:0], "R6 eoiOutVec", eoiOutVec, mEoiVec);
      chk(eoiOutLevel == mEoiLvl, "R7 eoiOutLevel", eoiOutLevel, mEoiLvl);
    end
  endtask

  task automatic step(input bit rv, input logic [7:0] v, input bit lv,
                      input bit tw, input logic [7:0] td, input bit ak, input bit eo);
    reqValid = rv; reqVec = v; reqLevel = lv;
    tprWrValid = tw; tprWrData = td; ackStrobe = ak; eoiStrobe = eo;
    @(posedge clk);
    modelUpdate();
    @(negedge clk);
    compareAll();
    reqValid = 0; tprWrValid = 0; ackStrobe = 0; eoiStrobe = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(dlvValid == 0, "R1 dlvValid", dlvValid, 0);
    chk(procPri == 0, "R1 procPri", procPri, 0);
    chk(eoiOutValid == 0, "R1 eoiOutValid", eoiOutValid, 0);
    chk(reqNew == 0, "R1 reqNew", reqNew, 0);

    // R10 gating by each enable
    hwEnable = 0; swEnable = 1;
    step(1, 8'h40, 0, 0, 0, 0, 0);
    chk(reqNew == 0 && dlvValid == 0, "R10 hw off", dlvValid, 0);
    hwEnable = 1; swEnable = 0;
    step(1, 8'h40, 0, 0, 0, 0, 0);
    chk(reqNew == 0 && dlvValid == 0, "R10 sw off", dlvValid, 0);
    swEnable = 1;

    step(1, 8'h35, 0, 0, 0, 0, 0);
    chk(reqNew == 1, "R11 new pulse", reqNew, 1);
    chk(dlvVec == 8'h35, "R2 first", dlvVec, 8'h35);
    step(0, 0, 0, 0, 0, 0, 0);
    chk(reqNew == 0, "R11 one cycle", reqNew, 0);
    step(1, 8'h92, 1, 0, 0, 0, 0);
    chk(dlvVec == 8'h92, "R2 upper word", dlvVec, 8'h92);

    step(0, 0, 0, 1, 8'hA5, 0, 0);
    chk(procPri == 8'hA5, "R9 tpr write", procPri, 8'hA5);
    chk(dlvValid == 0, "R4 below tpr", dlvValid, 0);
    step(0, 0, 0, 1, 8'h90, 0, 0);
    chk(dlvValid == 0, "R4 equal class blocked", dlvValid, 0);
    step(0, 0, 0, 1, 8'h8F, 0, 0);
    chk(dlvValid == 1 && dlvVec == 8'h92, "R4 just above", dlvVec, 8'h92);
    step(0, 0, 0, 1, 8'h00, 0, 0);

    step(0, 0, 0, 0, 0, 1, 0);
    chk(dlvValid == 0, "R5 acked vector gone", dlvValid, 0);
    chk(procPri == 8'h90, "R3 isr class", procPri, 8'h90);
    step(0, 0, 0, 1, 8'hA3, 0, 0);
    chk(procPri == 8'hA3, "R3 tpr above isr", procPri, 8'hA3);
    step(0, 0, 0, 1, 8'h95, 0, 0);
    chk(procPri == 8'h95, "R3 tpr same class", procPri, 8'h95);
    step(0, 0, 0, 1, 8'h40, 0, 0);
    chk(procPri == 8'h90, "R3 isr above tpr", procPri, 8'h90);
    step(0, 0, 0, 1, 8'h00, 0, 0);

    step(1, 8'h35, 1, 0, 0, 0, 0);
    chk(reqNew == 0, "R8 level dup dropped", reqNew, 0);
    step(0, 0, 0, 0, 0, 0, 1);
    chk(eoiOutValid == 1 && eoiOutVec == 8'h92, "R6 retire vec", eoiOutVec, 8'h92);
    chk(eoiOutLevel == 1, "R7 level kind", eoiOutLevel, 1);
    chk(dlvVec == 8'h35 && dlvValid == 1, "R2 next offered", dlvVec, 8'h35);
    step(0, 0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 0, 1);
    chk(eoiOutLevel == 0 && eoiOutVec == 8'h35, "R8 kind kept edge", eoiOutLevel, 0);
    step(0, 0, 0, 0, 0, 0, 1);
    chk(eoiOutValid == 0, "R6 empty eoi", eoiOutValid, 0);
    step(0, 0, 0, 0, 0, 1, 0);
    chk(dlvValid == 0 && procPri == 0, "R5 ack with nothing", procPri, 0);

    step(1, 8'h35, 0, 0, 0, 0, 0);
    step(1, 8'h35, 1, 0, 0, 1, 0);
    chk(reqNew == 1, "R12 ack then accept same vector", reqNew, 1);
    chk(dlvValid == 0, "R12 repended below ppr", dlvValid, 0);
    step(0, 0, 0, 0, 0, 0, 1);
    chk(eoiOutLevel == 1, "R12 accept overwrote kind", eoiOutLevel, 1);

    // random phase with collisions
    for (int n = 0; n < 2000; n++) begin
      hwEnable = ($urandom_range(0, 15) != 0);
      swEnable = ($urandom_range(0, 15) != 0);
      step($urandom_range(0, 1) == 1, 8'($urandom_range(0, 255)),
           $urandom_range(0, 1) == 1, $urandom_range(0, 7) == 0,
           8'($urandom_range(0, 255)), $urandom_range(0, 2) == 0,
           $urandom_range(0, 3) == 0);
    end
    summary();
  end
endmodule